// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block looks after the life-support side of an asynchronous DRAM that sits next to a separate access controller. After reset it keeps the strobes idle for a power-on pause measured in clocks. It then runs a set number of wake-up cycles and only after that reports the memory as ready. From then on it schedules CAS-before-RAS refresh cycles at a fixed clock spacing. The spacing is chosen so that every row is refreshed within the retention period. For example, 2,048 rows in 32 ms gives one cycle about every 15.6 µs.

The sequencer never takes the memory pins on its own initiative. It raises a request and waits for the access controller to grant it. The grant is sampled on a clock edge, and the sequencer then drives the row and column strobes for one refresh cycle. In that cycle the column strobe goes low first, the row strobe follows after a lead time, both stay low for the active time, and both then return high for the precharge time. The refresh needs no address, because the memory takes the row from its own counter.

A grant can fail to arrive within a set number of clocks. When that happens the block sets a sticky overdue flag, withdraws the ready indication and repeats the whole wake-up sequence before it reports ready again.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and right after it, ras_n and cas_n are 1 and ref_req, mem_ready and overdue are 0.
- R2: ref_req first goes high on the PAUSE_CLKS-th rising clock edge after reset is released. Up to that edge, ras_n and cas_n stay 1.
- R3: Once a grant is accepted on a rising edge, the strobes follow this sequence over the next cycles. cas_n is 0 and ras_n is 1 for LEAD_CLKS cycles. Both are 0 for ACT_CLKS cycles. Both are 1 for PRE_CLKS cycles. The column strobe is therefore always low before the row strobe falls.
- R4: ref_req stays at 1 until ref_gnt is sampled at 1, and it is 0 for the whole refresh cycle. Whenever no refresh cycle is in progress, ras_n and cas_n are 1.
- R5: mem_ready rises on the edge that completes the WAKE_CYCLES-th wake-up cycle and not before. Between wake-up cycles, ref_req is high again directly after each cycle ends.
- R6: Once mem_ready is 1, ref_req rises REF_INTERVAL+1 clocks after mem_ready rose and then every REF_INTERVAL clocks, whatever the grant delay was.
- R7: If ref_gnt is sampled at 1 within GRANT_LIMIT rising edges of ref_req going high, overdue stays 0. If it is not, overdue becomes 1 on the GRANT_LIMIT-th edge and stays 1 until reset.
- R8: When overdue is set, mem_ready falls on the same edge and ref_req stays high. WAKE_CYCLES complete cycles must then run again before mem_ready returns to 1.
- R9: ref_gnt has no effect while ref_req is 0. It starts no cycle, leaves ras_n and cas_n at 1 and does not shift the refresh schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Access controller hands the memory pins to this block |
| ref_req | output | 1 | Request for one refresh or wake-up cycle |
| ras_n | output | 1 | Row strobe, active low, valid during this block's cycles |
| cas_n | output | 1 | Column strobe, active low, valid during this block's cycles |
| mem_ready | output | 1 | Initialization complete, normal accesses allowed |
| overdue | output | 1 | Sticky flag: a refresh grant came too late |

## Verification
The situation hardest to reach is the late-grant recovery. The controller must stay silent for exactly the grant limit while a normal refresh is pending. The sequencer must then fall back into a complete wake-up run, with the ready flag low, and come back out of it. The bench reaches this state in stages. It first sweeps every grant delay below the limit and shows that none of them raises the flag or moves the schedule. It then withholds the grant for exactly the limit, checks the edge on which the flag appears, and finally grants the repeated wake-up cycles and measures the schedule after readiness returns.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

   typedef enum logic [1:0] {
      SQ_PAUSE,
      SQ_IDLE,
      SQ_REQ,
      SQ_CYC
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_LEAD,
      PH_ACT,
      PH_PRE
   } cbr_phase_t;

endpackage

// File: rtl/seq_count.sv
module seq_count #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic hit
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("seq_count: LIMIT must be at least 1");
      end

      if (LIMIT == 1) begin : g_single
         assign hit = en && !clr;
      end else begin : g_counter
         logic [CW-1:0] cnt;

         assign hit = en && !clr && (cnt == CW'(LIMIT - 1));

         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               cnt <= '0;
            end else if (en) begin
               cnt <= hit ? '0 : cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cbr_phase.sv
module cbr_phase
   import dram_ref_pkg::*;
#(
   parameter int LEAD_CLKS = 1,
   parameter int ACT_CLKS  = 3,
   parameter int PRE_CLKS  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ras_n,
   output logic cas_n,
   output logic done
);
   localparam int MAXL = (LEAD_CLKS > ACT_CLKS) ?
                         ((LEAD_CLKS > PRE_CLKS) ? LEAD_CLKS : PRE_CLKS) :
                         ((ACT_CLKS > PRE_CLKS) ? ACT_CLKS : PRE_CLKS);
   localparam int CW = $clog2(MAXL + 1);

   generate
      if (LEAD_CLKS < 1 || ACT_CLKS < 1 || PRE_CLKS < 1) begin : g_bad_len
         $error("cbr_phase: every phase needs at least one clock");
      end
   endgenerate

   cbr_phase_t    phase;
   logic [CW-1:0] cnt;
   int            cur_len;
   logic          last;

   always_comb begin
      case (phase)
         PH_LEAD: cur_len = LEAD_CLKS;
         PH_ACT:  cur_len = ACT_CLKS;
         default: cur_len = PRE_CLKS;
      endcase
   end

   assign last  = (cnt == CW'(cur_len - 1));
   assign cas_n = !((phase == PH_LEAD) || (phase == PH_ACT));
   assign ras_n = (phase != PH_ACT);
   assign done  = (phase == PH_PRE) && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               cnt <= '0;
               if (start) phase <= PH_LEAD;
            end
            PH_LEAD: begin
               cnt <= last ? '0 : cnt + 1'b1;
               if (last) phase <= PH_ACT;
            end
            PH_ACT: begin
               cnt <= last ? '0 : cnt + 1'b1;
               if (last) phase <= PH_PRE;
            end
            default: begin
               cnt <= last ? '0 : cnt + 1'b1;
               if (last) phase <= PH_IDLE;
            end
         endcase
      end
   end

   // R3
   cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

   // R3
   joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> $rose(cas_n));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import dram_ref_pkg::*;
#(
   parameter int PAUSE_CLKS   = 20000,
   parameter int WAKE_CYCLES  = 8,
   parameter int REF_INTERVAL = 1560,
   parameter int GRANT_LIMIT  = 200,
   parameter int LEAD_CLKS    = 1,
   parameter int ACT_CLKS     = 5,
   parameter int PRE_CLKS     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_gnt,
   output logic ref_req,
   output logic ras_n,
   output logic cas_n,
   output logic mem_ready,
   output logic overdue
);
   localparam int CYC_CLKS = LEAD_CLKS + ACT_CLKS + PRE_CLKS;
   localparam int WW       = $clog2(WAKE_CYCLES + 1);

   generate
      if (WAKE_CYCLES < 1) begin : g_bad_wake
         $error("dram_refresh_seq: WAKE_CYCLES must be at least 1");
      end
      if (REF_INTERVAL <= GRANT_LIMIT + CYC_CLKS + 1) begin : g_bad_interval
         $error("dram_refresh_seq: REF_INTERVAL too short for grant wait and cycle");
      end
   endgenerate

   seq_state_t    state;
   logic [WW-1:0] wake_left;
   logic          pending;
   logic          start;
   logic          pause_hit;
   logic          tick;
   logic          wait_hit;
   logic          cyc_done;

   assign ref_req = (state == SQ_REQ);
   assign start   = ref_req && ref_gnt;

   seq_count #(.LIMIT(PAUSE_CLKS)) i_pause (
      .clk(clk), .rst_n(rst_n), .clr(1'b0),
      .en(state == SQ_PAUSE), .hit(pause_hit)
   );

   seq_count #(.LIMIT(REF_INTERVAL)) i_interval (
      .clk(clk), .rst_n(rst_n), .clr(!mem_ready),
      .en(1'b1), .hit(tick)
   );

   seq_count #(.LIMIT(GRANT_LIMIT)) i_wait (
      .clk(clk), .rst_n(rst_n), .clr(!ref_req || ref_gnt),
      .en(1'b1), .hit(wait_hit)
   );

   cbr_phase #(
      .LEAD_CLKS(LEAD_CLKS), .ACT_CLKS(ACT_CLKS), .PRE_CLKS(PRE_CLKS)
   ) i_phase (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ras_n(ras_n), .cas_n(cas_n), .done(cyc_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SQ_PAUSE;
         wake_left <= '0;
         mem_ready <= 1'b0;
         overdue   <= 1'b0;
         pending   <= 1'b0;
      end else begin
         if (tick) begin
            pending <= 1'b1;
         end else if (start || !mem_ready) begin
            pending <= 1'b0;
         end

         case (state)
            SQ_PAUSE: begin
               if (pause_hit) begin
                  state     <= SQ_REQ;
                  wake_left <= WW'(WAKE_CYCLES);
               end
            end
            SQ_IDLE: begin
               if (pending) state <= SQ_REQ;
            end
            SQ_REQ: begin
               if (ref_gnt) begin
                  state <= SQ_CYC;
               end else if (wait_hit) begin
                  overdue   <= 1'b1;
                  mem_ready <= 1'b0;
                  wake_left <= WW'(WAKE_CYCLES);
               end
            end
            default: begin
               if (cyc_done) begin
                  if (wake_left == WW'(1)) begin
                     wake_left <= '0;
                     mem_ready <= 1'b1;
                     state     <= SQ_IDLE;
                  end else if (wake_left != '0) begin
                     wake_left <= wake_left - 1'b1;
                     state     <= SQ_REQ;
                  end else begin
                     state <= SQ_IDLE;
                  end
               end
            end
         endcase
      end
   end

   // R2
   quiet_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_PAUSE) |-> (ras_n && cas_n && !ref_req));

   // R4
   no_req_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n || !cas_n) |-> !ref_req);

   // R4
   strobes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE || state == SQ_REQ) |-> (ras_n && cas_n));

   // R5
   ready_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ready) |-> $past(cyc_done));

   // R7
   overdue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overdue |=> overdue);

   // R8
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overdue) |-> (!mem_ready && ref_req));

endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
   localparam int CLK_PERIOD = 10;
   localparam int PAUSE  = 20;
   localparam int WAKE   = 3;
   localparam int INTV   = 40;
   localparam int GLIM   = 6;
   localparam int LEAD   = 1;
   localparam int ACT    = 3;
   localparam int PRE    = 2;
   localparam int CYCL   = LEAD + ACT + PRE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_gnt = 1'b0;
   logic ref_req, ras_n, cas_n, mem_ready, overdue;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int t_ready = 0;
   int t_req = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dram_refresh_seq #(
      .PAUSE_CLKS(PAUSE), .WAKE_CYCLES(WAKE), .REF_INTERVAL(INTV),
      .GRANT_LIMIT(GLIM), .LEAD_CLKS(LEAD), .ACT_CLKS(ACT), .PRE_CLKS(PRE)
   ) i_dram_refresh_seq (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
      .ras_n(ras_n), .cas_n(cas_n), .mem_ready(mem_ready), .overdue(overdue)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // Called at a sample point where ref_req should be high; grants after d idle edges
   task automatic grant_cycle(input int d);
      chk(ref_req == 1'b1, "R4 request present", ref_req, 1);
      for (int i = 0; i < d; i++) begin
         @(negedge clk);
         chk(ref_req == 1'b1, "R4 request held", ref_req, 1);
         chk(ras_n && cas_n, "R4 strobes idle while waiting", {ras_n, cas_n}, 3);
      end
      ref_gnt = 1'b1;
      @(negedge clk);
      ref_gnt = 1'b0;
      for (int k = 1; k <= CYCL; k++) begin
         bit ec = (k <= LEAD + ACT) ? 1'b0 : 1'b1;
         bit er = (k > LEAD && k <= LEAD + ACT) ? 1'b0 : 1'b1;
         chk(cas_n == ec, "R3 cas_n shape", cas_n, ec);
         chk(ras_n == er, "R3 ras_n shape", ras_n, er);
         chk(ref_req == 1'b0, "R4 no request in cycle", ref_req, 0);
         @(negedge clk);
      end
   endtask

   task automatic wait_req(input bit hold_gnt);
      int n = 0;
      ref_gnt = hold_gnt;
      while (!ref_req && n < 1000) begin
         chk(ras_n && cas_n, "R9 strobes idle without request", {ras_n, cas_n}, 3);
         @(negedge clk);
         n++;
      end
      ref_gnt = 1'b0;
   endtask

   task automatic wake_run(input string tag);
      for (int w = 0; w < WAKE; w++) begin
         chk(mem_ready == 1'b0, tag, mem_ready, 0);
         grant_cycle(w % GLIM);
         if (w < WAKE - 1)
            chk(ref_req == 1'b1, "R5 next wake request", ref_req, 1);
      end
      chk(mem_ready == 1'b1, tag, mem_ready, 1);
      t_ready = cyc;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk(ras_n && cas_n, "R1 strobes in reset", {ras_n, cas_n}, 3);
      chk(!ref_req && !mem_ready && !overdue, "R1 flags in reset",
          {ref_req, mem_ready, overdue}, 0);
      rst_n = 1'b1;
      t_req = cyc;
      @(negedge clk);
      chk(!ref_req && !mem_ready && !overdue, "R1 flags after reset",
          {ref_req, mem_ready, overdue}, 0);
      // R2
      while (!ref_req && (cyc - t_req) < 1000) begin
         chk(ras_n && cas_n, "R2 strobes idle in pause", {ras_n, cas_n}, 3);
         @(negedge clk);
      end
      chk(cyc - t_req == PAUSE, "R2 pause length", cyc - t_req, PAUSE);

      // R5
      wake_run("R5 ready after wake-up run");

      // R6 first request after ready
      wait_req(1'b0);
      chk(cyc - t_ready == INTV + 1, "R6 first refresh spacing", cyc - t_ready, INTV + 1);
      t_req = cyc;

      // R7 sweep every grant delay below the limit
      for (int d = 0; d < GLIM; d++) begin
         grant_cycle(d);
         chk(overdue == 1'b0, "R7 no overdue for timely grant", overdue, 0);
         wait_req(d == 2);  // R9 grant held during idle on one pass
         chk(cyc - t_req == INTV, "R6 refresh period", cyc - t_req, INTV);
         t_req = cyc;
      end

      // R7 / R8 withheld grant
      for (int k = 1; k <= GLIM; k++) begin
         @(negedge clk);
         if (k < GLIM) begin
            chk(overdue == 1'b0, "R7 overdue not early", overdue, 0);
         end else begin
            chk(overdue == 1'b1, "R7 overdue at limit", overdue, 1);
            chk(mem_ready == 1'b0, "R8 ready dropped", mem_ready, 0);
            chk(ref_req == 1'b1, "R8 request kept", ref_req, 1);
         end
      end

      // R8 wake-up repeated
      wake_run("R8 ready after repeated wake-up");
      chk(overdue == 1'b1, "R7 overdue sticky", overdue, 1);
      wait_req(1'b0);
      chk(cyc - t_ready == INTV + 1, "R6 spacing after recovery", cyc - t_ready, INTV + 1);
      grant_cycle(0);
      chk(overdue == 1'b1, "R7 overdue still sticky", overdue, 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule